// File: doc/BRIEF.md
# Capture Timer with Byte-Wide Atomic Access

This block is a 16-bit up-counter with one capture channel, reached from an 8-bit processor bus. On a rising edge of the chosen capture source, the running count is copied into a 16-bit capture register and the capture flag is raised. The source is either an external pin or a comparator output. Both inputs pass through a synchroniser before their edges are detected. Software picks the source with a control bit.

Every 16-bit register (counter, capture, compare A, compare B) sits at two byte addresses. All of them use one shared 8-bit holding latch. A low-byte read copies the high byte into the latch in the same cycle, and a later high-byte read returns the latch. A high-byte write fills the latch, and a low-byte write commits latch and low byte together. Software therefore always sees and loads a whole 16-bit value from one instant.

The counter wraps either at all ones or at the capture value, which then acts as the period. Wrapping raises the overflow flag. Matches against the two compare registers raise their own flags. Four interrupt lines each combine a flag, its enable bit in the mask register and a global enable input.

Top module: `tcap_top`

## Requirements
- R1: After reset, the counter, capture, compare, control, mask and flag registers are zero, and all four interrupt lines are low.
- R2: On a rising edge of the selected source, after the synchroniser, the capture register (addresses 0x6 low, 0x7 high) takes the counter value and flag bit 5 is set. The counter value is taken whether the counter is stopped or running.
- R3: Control bit 1 (address 0x0) selects the capture source: 0 selects the pin and 1 selects the comparator input. Edges on the other source change neither the capture register nor the flag.
- R4: A read of any low byte (even address) copies that register's high byte into the shared latch in the same cycle. A read of any high byte (odd address) returns the latch, even if the register has changed since.
- R5: A write to any high byte stores into the shared latch. A write to a low byte loads the register with the latch in the upper byte and the written byte in the lower byte. Compare A is at 0x8/0x9, compare B at 0xA/0xB and the counter at 0x4/0x5.
- R6: The mask register at 0x1 holds enables at bit 5 (capture), bit 2 (compare B), bit 1 (compare A) and bit 0 (overflow). Bits 7:6 and 4:3 always read as zero.
- R7: Each interrupt line is high exactly when its flag, its mask bit and the global enable input are all high.
- R8: The flag register at 0x2 uses the same bit positions as the mask. Writing a one to a bit clears that flag, and writing a zero has no effect. If a flag is set and cleared in the same cycle, the set wins.
- R9: When control bit 0 is set the counter increments each cycle. With control bit 2 clear it wraps from 0xFFFF to 0 and sets flag bit 0.
- R10: With control bit 2 set, the counter wraps to 0 after reaching the capture value and sets flag bit 0.
- R11: While the counter runs, a counter value equal to compare A sets flag bit 1, and a value equal to compare B sets flag bit 2.
- R12: If a capture and a capture low-byte read fall in the same cycle, the read returns the old low byte and the latch takes the old high byte. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (applies latch side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cap_pin | input | 1 | External capture pin (asynchronous) |
| cmp_in | input | 1 | Comparator capture input (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow/period interrupt request |

## Verification
The capture path is tested with a frozen counter, so the captured value is known exactly. It is also tested with a running counter whose high byte changes between the two halves of a read, which separates a latched high byte from a live one. Edges are sent on both sources under both select values to show that the unselected source is ignored. One capture edge is timed to land in the same cycle as a low-byte read, to show that the old value is returned whole. The period is tested in both wrap modes, with a small capture-defined period that a free-running counter would overshoot. Interrupt lines are checked across every combination of flag, mask bit and global enable.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int BUS_W  = 8;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int ADDR_W = 4;

    localparam int BIT_OVF  = 0;
    localparam int BIT_CMPA = 1;
    localparam int BIT_CMPB = 2;
    localparam int BIT_CAP  = 5;

    localparam logic [BUS_W-1:0] EVT_BITS = 8'b0010_0111;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'h1;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'h2;
    localparam logic [ADDR_W-1:0] A_CNT_L  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CNT_H  = 4'h5;
    localparam logic [ADDR_W-1:0] A_CAP_L  = 4'h6;
    localparam logic [ADDR_W-1:0] A_CAP_H  = 4'h7;
    localparam logic [ADDR_W-1:0] A_CMPA_L = 4'h8;
    localparam logic [ADDR_W-1:0] A_CMPA_H = 4'h9;
    localparam logic [ADDR_W-1:0] A_CMPB_L = 4'hA;
    localparam logic [ADDR_W-1:0] A_CMPB_H = 4'hB;

    typedef struct packed {
        logic top_cap;
        logic src_cmp;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic cap;
        logic cmpb;
        logic cmpa;
        logic ovf;
    } evt_t;

    function automatic logic [BUS_W-1:0] evt_to_byte(input evt_t e);
        logic [BUS_W-1:0] b;
        b = '0;
        b[BIT_CAP]  = e.cap;
        b[BIT_CMPB] = e.cmpb;
        b[BIT_CMPA] = e.cmpa;
        b[BIT_OVF]  = e.ovf;
        return b;
    endfunction

    function automatic evt_t byte_to_evt(input logic [BUS_W-1:0] b);
        evt_t e;
        e.cap  = b[BIT_CAP];
        e.cmpb = b[BIT_CMPB];
        e.cmpa = b[BIT_CMPA];
        e.ovf  = b[BIT_OVF];
        return e;
    endfunction

endpackage

// File: rtl/tcap_edge_detect.sv
module tcap_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter
    import tcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             top_cap,
    input  logic [CNT_W-1:0] cap_val,
    input  logic [CNT_W-1:0] cmpa_val,
    input  logic [CNT_W-1:0] cmpb_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             cmpa_evt,
    output logic             cmpb_evt
);
    logic [CNT_W-1:0] top_val;
    logic             at_top;

    assign top_val  = top_cap ? cap_val : {CNT_W{1'b1}};
    assign at_top   = (cnt == top_val);
    assign ovf_evt  = run & at_top;
    assign cmpa_evt = run & (cnt == cmpa_val);
    assign cmpb_evt = run & (cnt == cmpb_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tcap_flag_unit.sv
module tcap_flag_unit
    import tcap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t set_evt,
    input  evt_t clr_evt,
    input  evt_t mask,
    input  logic gie,
    output evt_t flags,
    output evt_t irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_evt) | set_evt;
        end
    end

    assign irq = flags & mask & {4{gie}};
endmodule

// File: rtl/tcap_top.sv
module tcap_top
    import tcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cap_pin,
    input  logic              cmp_in,
    input  logic              gie,
    output logic              irq_cap,
    output logic              irq_cmpa,
    output logic              irq_cmpb,
    output logic              irq_ovf
);
    localparam int NSRC = 2;

    ctrl_t            ctrl_q;
    evt_t             mask_q;
    evt_t             flags_q;
    evt_t             irq_v;
    evt_t             set_v;
    evt_t             clr_v;
    logic [BUS_W-1:0] temp_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cmpa_q;
    logic [CNT_W-1:0] cmpb_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wide_wdata;
    logic [NSRC-1:0]  src_raw;
    logic [NSRC-1:0]  src_rise;
    logic             cap_evt;
    logic             cnt_load;
    logic             ovf_e, cmpa_e, cmpb_e;

    assign src_raw = {cmp_in, cap_pin};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        tcap_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst  (rst),
            .din  (src_raw[s]),
            .rise (src_rise[s])
        );
    end

    assign cap_evt    = ctrl_q.src_cmp ? src_rise[1] : src_rise[0];
    assign wide_wdata = {temp_q, bus_wdata};
    assign cnt_load   = bus_wr && (bus_addr == A_CNT_L);

    tcap_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .top_cap  (ctrl_q.top_cap),
        .cap_val  (cap_q),
        .cmpa_val (cmpa_q),
        .cmpb_val (cmpb_q),
        .load     (cnt_load),
        .load_val (wide_wdata),
        .cnt      (cnt_q),
        .ovf_evt  (ovf_e),
        .cmpa_evt (cmpa_e),
        .cmpb_evt (cmpb_e)
    );

    always_comb begin
        set_v.cap  = cap_evt;
        set_v.cmpb = cmpb_e;
        set_v.cmpa = cmpa_e;
        set_v.ovf  = ovf_e;
        clr_v      = (bus_wr && bus_addr == A_FLAG) ? byte_to_evt(bus_wdata) : '0;
    end

    tcap_flag_unit u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_v),
        .clr_evt (clr_v),
        .mask    (mask_q),
        .gie     (gie),
        .flags   (flags_q),
        .irq     (irq_v)
    );

    assign irq_cap  = irq_v.cap;
    assign irq_cmpa = irq_v.cmpa;
    assign irq_cmpb = irq_v.cmpb;
    assign irq_ovf  = irq_v.ovf;

    // Register file and shared high-byte latch
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            temp_q <= '0;
            cap_q  <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL:   ctrl_q <= ctrl_t'(bus_wdata[2:0]);
                    A_MASK:   mask_q <= byte_to_evt(bus_wdata);
                    A_CNT_H,
                    A_CAP_H,
                    A_CMPA_H,
                    A_CMPB_H: temp_q <= bus_wdata;
                    A_CMPA_L: cmpa_q <= wide_wdata;
                    A_CMPB_L: cmpb_q <= wide_wdata;
                    default:  ;
                endcase
            end else if (bus_rd) begin
                case (bus_addr)
                    A_CNT_L:  temp_q <= cnt_q[CNT_W-1:BUS_W];
                    A_CAP_L:  temp_q <= cap_q[CNT_W-1:BUS_W];
                    A_CMPA_L: temp_q <= cmpa_q[CNT_W-1:BUS_W];
                    A_CMPB_L: temp_q <= cmpb_q[CNT_W-1:BUS_W];
                    default:  ;
                endcase
            end
            if (cap_evt) begin
                cap_q <= cnt_q;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = {5'b0, ctrl_q};
            A_MASK:   bus_rdata = evt_to_byte(mask_q);
            A_FLAG:   bus_rdata = evt_to_byte(flags_q);
            A_CNT_L:  bus_rdata = cnt_q[BUS_W-1:0];
            A_CAP_L:  bus_rdata = cap_q[BUS_W-1:0];
            A_CMPA_L: bus_rdata = cmpa_q[BUS_W-1:0];
            A_CMPB_L: bus_rdata = cmpb_q[BUS_W-1:0];
            A_CNT_H,
            A_CAP_H,
            A_CMPA_H,
            A_CMPB_H: bus_rdata = temp_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcap_checker.sv
module tcap_checker
    import tcap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              gie,
    input logic              irq_any,
    input logic              run,
    input logic              top_cap,
    input logic              cap_evt,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cap_q,
    input logic [BUS_W-1:0]  temp_q,
    input logic [BUS_W-1:0]  flag_byte
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == A_CNT_L);

    assert_cap_load_R2: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap_q == $past(cnt_q)) && flag_byte[BIT_CAP]);

    assert_latch_on_low_read_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == A_CAP_L) |=> (temp_q == $past(cap_q[CNT_W-1:BUS_W])));

    assert_mask_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_MASK) |-> ((bus_rdata & ~EVT_BITS) == '0));

    assert_irq_needs_gie_R7: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> gie);

    assert_flag_clear_by_write_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_byte[BIT_CAP]) |-> $past(bus_wr && bus_addr == A_FLAG && bus_wdata[BIT_CAP]));

    assert_free_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (run && !top_cap && cnt_q == {CNT_W{1'b1}} && !cnt_wr) |=> (cnt_q == '0) && flag_byte[BIT_OVF]);

    assert_period_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (run && top_cap && cnt_q == cap_q && !cnt_wr) |=> (cnt_q == '0) && flag_byte[BIT_OVF]);
endmodule

bind tcap_top tcap_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gie       (gie),
    .irq_any   (irq_cap | irq_cmpa | irq_cmpb | irq_ovf),
    .run       (ctrl_q.run),
    .top_cap   (ctrl_q.top_cap),
    .cap_evt   (cap_evt),
    .cnt_q     (cnt_q),
    .cap_q     (cap_q),
    .temp_q    (temp_q),
    .flag_byte (tcap_pkg::evt_to_byte(flags_q))
);

// File: tb/tcap_top_test.sv
module tcap_top_test;
    import tcap_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cmp_in = 1'b0;
    logic       gie = 1'b0;
    logic       irq_cap, irq_cmpa, irq_cmpb, irq_ovf;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tcap_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin), .cmp_in(cmp_in),
        .gie(gie), .irq_cap(irq_cap), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic write16(input logic [3:0] lo_addr, input logic [15:0] v);
        bus_write(lo_addr + 4'd1, v[15:8]);
        bus_write(lo_addr, v[7:0]);
    endtask

    task automatic read16(input logic [3:0] lo_addr, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(lo_addr, lo);
        bus_read(lo_addr + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input bit use_cmp);
        @(negedge clk);
        if (use_cmp) cmp_in = 1'b1; else cap_pin = 1'b1;
        repeat (6) @(negedge clk);
        if (use_cmp) cmp_in = 1'b0; else cap_pin = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        logic [7:0]  b;
        read16(A_CNT_L, v);  check("R1 counter", v, 16'h0);
        read16(A_CAP_L, v);  check("R1 capture", v, 16'h0);
        read16(A_CMPA_L, v); check("R1 compare A", v, 16'h0);
        bus_read(A_MASK, b); check("R1 mask", {8'h0, b}, 16'h0);
        bus_read(A_FLAG, b); check("R1 flags", {8'h0, b}, 16'h0);
        gie = 1'b1; #1;
        check("R1 irq lines", {12'h0, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0);
        gie = 1'b0;
    endtask

    task automatic t_capture_frozen;
        logic [15:0] v;
        logic [7:0]  b;
        write16(A_CNT_L, 16'h1234);
        pulse(1'b0);
        read16(A_CAP_L, v);  check("R2 capture of stopped counter", v, 16'h1234);
        bus_read(A_FLAG, b); check("R2 capture flag", {8'h0, b & 8'h20}, 16'h0020);
    endtask

    task automatic t_compare_regs;
        logic [15:0] v;
        write16(A_CMPA_L, 16'hABCD);
        read16(A_CMPA_L, v); check("R5 compare A 16-bit write", v, 16'hABCD);
        bus_write(A_CMPB_H, 8'h11);
        bus_write(A_CMPA_L, 8'h22);
        read16(A_CMPA_L, v); check("R5 shared latch across registers", v, 16'h1122);
    endtask

    task automatic t_source_select;
        logic [15:0] v;
        logic [7:0]  b;
        bus_write(A_CTRL, 8'h02);
        write16(A_CNT_L, 16'h4444);
        bus_write(A_FLAG, 8'hFF);
        pulse(1'b0);
        read16(A_CAP_L, v);  check("R3 pin ignored when comparator selected", v, 16'h1234);
        bus_read(A_FLAG, b); check("R3 no flag from unselected source", {8'h0, b & 8'h20}, 16'h0);
        pulse(1'b1);
        read16(A_CAP_L, v);  check("R3 comparator capture", v, 16'h4444);
        bus_write(A_CTRL, 8'h00);
        write16(A_CNT_L, 16'h5555);
        pulse(1'b1);
        read16(A_CAP_L, v);  check("R3 comparator ignored when pin selected", v, 16'h4444);
    endtask

    task automatic t_atomic_read;
        logic [7:0]  lo, hi;
        logic [15:0] v;
        write16(A_CNT_L, 16'h00F0);
        pulse(1'b0);
        bus_read(A_CAP_L, lo);
        check("R4 low byte", {8'h0, lo}, 16'h00F0);
        bus_write(A_CTRL, 8'h01);
        repeat (30) @(negedge clk);
        pulse(1'b0);
        bus_write(A_CTRL, 8'h00);
        bus_read(A_CAP_H, hi);
        check("R4 high byte from latch after change", {8'h0, hi}, 16'h0000);
        read16(A_CAP_L, v);
        check("R2 running capture high byte", {8'h0, v[15:8]}, 16'h0001);
    endtask

    task automatic t_collision;
        logic [7:0] b;
        write16(A_CNT_L, 16'h5678);
        pulse(1'b0);
        write16(A_CNT_L, 16'h9ABC);
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk);
        bus_read(A_CAP_L, b); check("R12 old low on collision", {8'h0, b}, 16'h0078);
        bus_read(A_CAP_H, b); check("R12 old high in latch", {8'h0, b}, 16'h0056);
        bus_read(A_CAP_L, b); check("R12 new low next", {8'h0, b}, 16'h00BC);
        bus_read(A_CAP_H, b); check("R12 new high next", {8'h0, b}, 16'h009A);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_free_wrap;
        logic [15:0] v;
        logic [7:0]  b;
        write16(A_CNT_L, 16'hFFF8);
        bus_write(A_FLAG, 8'hFF);
        bus_read(A_FLAG, b); check("R9 no overflow before wrap", {8'h0, b & 8'h01}, 16'h0);
        bus_write(A_CTRL, 8'h01);
        repeat (12) @(negedge clk);
        bus_write(A_CTRL, 8'h00);
        bus_read(A_FLAG, b); check("R9 overflow flag at wrap", {8'h0, b & 8'h01}, 16'h0001);
        read16(A_CNT_L, v);  check("R9 counter wrapped high byte", {8'h0, v[15:8]}, 16'h0);
    endtask

    task automatic t_period_wrap;
        logic [15:0] v;
        logic [7:0]  b;
        write16(A_CNT_L, 16'h0005);
        pulse(1'b0);
        write16(A_CNT_L, 16'h0000);
        bus_write(A_FLAG, 8'hFF);
        bus_write(A_CTRL, 8'h05);
        repeat (25) @(negedge clk);
        bus_write(A_CTRL, 8'h00);
        read16(A_CNT_L, v);
        check("R10 counter within capture period", {15'h0, (v <= 16'h0005)}, 16'h1);
        bus_read(A_FLAG, b); check("R10 period flag", {8'h0, b & 8'h01}, 16'h0001);
    endtask

    task automatic t_compare_flags;
        logic [7:0] b;
        write16(A_CMPA_L, 16'h0003);
        write16(A_CMPB_L, 16'h0100);
        write16(A_CNT_L, 16'h0000);
        bus_write(A_FLAG, 8'hFF);
        bus_write(A_CTRL, 8'h01);
        repeat (10) @(negedge clk);
        bus_write(A_CTRL, 8'h00);
        bus_read(A_FLAG, b);
        check("R11 compare A set, compare B clear", {8'h0, b & 8'h06}, 16'h0002);
    endtask

    task automatic t_mask_irq;
        logic [7:0] b;
        bus_write(A_MASK, 8'hFF);
        bus_read(A_MASK, b); check("R6 mask reserved bits zero", {8'h0, b}, 16'h0027);
        bus_write(A_FLAG, 8'hFF);
        pulse(1'b0);
        gie = 1'b0; #1;
        check("R7 all low without global enable", {12'h0, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0);
        gie = 1'b1; #1;
        check("R7 capture line only", {12'h0, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h8);
        bus_write(A_MASK, 8'h07); #1;
        check("R7 masked capture line", {12'h0, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0);
        gie = 1'b0;
    endtask

    task automatic t_flag_clear;
        logic [7:0] b;
        bus_write(A_FLAG, 8'h00);
        bus_read(A_FLAG, b); check("R8 zero write keeps flag", {8'h0, b}, 16'h0020);
        bus_write(A_FLAG, 8'h20);
        bus_read(A_FLAG, b); check("R8 one write clears flag", {8'h0, b}, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_capture_frozen();
        t_compare_regs();
        t_source_select();
        t_atomic_read();
        t_collision();
        t_free_wrap();
        t_period_wrap();
        t_compare_flags();
        t_mask_irq();
        t_flag_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule